// File: doc/BRIEF.md
# Power-Up Configuration Loader

After reset this block waits for a programmable start-up delay and then fetches a 28-byte configuration image from an external nonvolatile memory. It uses one request/response handshake per byte and accepts any response latency. Byte pairs become 16-bit words, with the even address as the low byte. All fourteen words go into a register file, which can be read through a plain address/data port once loading has finished.

The image is trusted only if three checks all pass. The first is a signature word. The other two are checksum words, each holding 0xFFFF minus the 16-bit truncated sum of its own range of words. The analog output enable rises only when all three pass. A failure flag is raised for each check that fails.

A lock bit in the image can switch off the serial programming interface after loading. This happens only when the image is valid and the host showed no traffic during a short early window after reset. Host traffic arrives as a single strobe.

Top module: `boot_cfg_loader`

## Requirements
- R1: No memory request is raised before START_DELAY clock cycles have passed since reset release. The first request appears exactly START_DELAY cycles after release.
- R2: Byte addresses 0 to 27 are requested once each, in ascending order. A request stays raised with a steady address until it is accepted (memReqValid and memReqReady both high). Each byte is taken from the first memRspValid pulse after acceptance, whatever the latency.
- R3: Register word k holds {byte 2k+1, byte 2k} for k = 0..13. After loadDone, rdData returns word rdAddr combinationally. Addresses 14 and 15 read as zero.
- R4: Word 8 (bytes 16/17) must equal the SIGNATURE parameter. Otherwise failFlags[0] is set.
- R5: Word 7 (bytes 14/15) must equal 0xFFFF minus the sum of words 0..6, truncated to 16 bits. Otherwise failFlags[1] is set.
- R6: Word 13 (bytes 26/27) must equal 0xFFFF minus the sum of words 8..12, truncated to 16 bits. Otherwise failFlags[2] is set.
- R7: outEn is low until loading ends. It then goes high only if all three checks pass.
- R8: loadDone is a single one-cycle pulse. outEn and failFlags take their final values in that same cycle and stay fixed afterwards.
- R9: progEn is high through reset and loading. After loading it goes low only when the image is valid, bit 15 of word 4 is 1, and no early host strobe was seen.
- R10: A hostStrobe sampled within the first EARLY_WINDOW cycles after reset release keeps progEn high even when the lock bit is set. A later strobe has no such effect.
- R11: When any failFlags bit is set, progEn stays high whatever the lock bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memReqValid | output | 1 | Byte read request |
| memReqAddr | output | 5 | Byte address of the request |
| memReqReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 8 | Read data byte |
| hostStrobe | input | 1 | Host traffic seen on the programming interface |
| rdAddr | input | 4 | Register file read address |
| rdData | output | 16 | Register file read data |
| loadDone | output | 1 | One-cycle pulse at end of loading |
| outEn | output | 1 | Output stage enable |
| failFlags | output | 3 | bit0 signature, bit1 checksum 1, bit2 checksum 2 |
| progEn | output | 1 | Programming interface enable |

## Verification
The bench builds the loader with START_DELAY = 40 and EARLY_WINDOW = 25 cycles. With these values the exact first-request cycle can be checked, and host strobes can be placed clearly inside the early window (cycle 5) or clearly after it (cycle 27) while still arriving before the fetch starts. Each run also changes the memory model's response latency (0 to 4 cycles) and whether ready is throttled every other cycle, so that the handshake is exercised under several timings. Image data is chosen so that both checksum sums wrap past 16 bits.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int IMG_BYTES = 28;
  localparam int IMG_WORDS = IMG_BYTES / 2;
  localparam int WORD_W    = 16;
  localparam int BYTE_W    = 8;
  localparam int CS1_IDX   = 7;
  localparam int SIG_IDX   = 8;
  localparam int CS2_IDX   = 13;
  localparam int LOCK_IDX  = 4;
  localparam int LOCK_BIT  = 15;
  localparam int ADDR_W    = $clog2(IMG_BYTES);
  localparam int WIDX_W    = $clog2(IMG_WORDS);
  localparam int FLAG_W    = 3;

  typedef struct packed {
    logic              capture;
    logic              evaluate;
    logic              windowOpen;
    logic [ADDR_W-1:0] byteAddr;
  } loadCtl_t;

  typedef enum logic [2:0] {
    ST_WAIT, ST_REQ, ST_RSP, ST_EVAL, ST_FIN
  } loadState_t;
endpackage

// File: rtl/boot_cfg_ctrl.sv
module boot_cfg_ctrl
  import boot_cfg_pkg::*;
#(
  parameter int START_DELAY  = 1650000,
  parameter int EARLY_WINDOW = 1250000
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     memReqReady,
  input  logic     memRspValid,
  output logic     memReqValid,
  output logic     loadDone,
  output loadCtl_t ctl
);
  localparam int DLY_W = $clog2(START_DELAY + 1);
  localparam int WIN_W = $clog2(EARLY_WINDOW + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(IMG_BYTES - 1);

  loadState_t        state;
  logic [DLY_W-1:0]  delayCnt;
  logic [WIN_W-1:0]  winCnt;
  logic [ADDR_W-1:0] byteAddr;
  logic              doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (winCnt != WIN_W'(EARLY_WINDOW)) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_WAIT;
      delayCnt <= '0;
      byteAddr <= '0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= (state == ST_EVAL);
      case (state)
        ST_WAIT: begin
          if (delayCnt == DLY_W'(START_DELAY - 1)) state <= ST_REQ;
          else delayCnt <= delayCnt + 1'b1;
        end
        ST_REQ: if (memReqReady) state <= ST_RSP;
        ST_RSP: begin
          if (memRspValid) begin
            if (byteAddr == LAST_ADDR) begin
              state <= ST_EVAL;
            end else begin
              byteAddr <= byteAddr + 1'b1;
              state    <= ST_REQ;
            end
          end
        end
        ST_EVAL: state <= ST_FIN;
        default: state <= ST_FIN;
      endcase
    end
  end

  always_comb begin
    memReqValid    = (state == ST_REQ);
    loadDone       = doneQ;
    ctl.capture    = (state == ST_RSP) && memRspValid;
    ctl.evaluate   = (state == ST_EVAL);
    ctl.windowOpen = (winCnt < WIN_W'(EARLY_WINDOW));
    ctl.byteAddr   = byteAddr;
  end
endmodule

// File: rtl/boot_cfg_dpath.sv
module boot_cfg_dpath
  import boot_cfg_pkg::*;
#(
  parameter logic [15:0] SIGNATURE = 16'h5A3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  loadCtl_t          ctl,
  input  logic [BYTE_W-1:0] memRspData,
  input  logic              hostStrobe,
  input  logic [WIDX_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic              outEn,
  output logic [FLAG_W-1:0] failFlags,
  output logic              progEn
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic [WORD_W-1:0] regFile [IMG_WORDS];
  logic [BYTE_W-1:0] lowByte;
  logic [WORD_W-1:0] sum1, sum2, newWord;
  logic [WIDX_W-1:0] wordIdx;
  logic              wordWr, inRange1, inRange2;
  logic              sigOk, cs1Ok, cs2Ok;
  logic              earlyHost, lockReq;

  assign wordIdx  = ctl.byteAddr[ADDR_W-1:1];
  assign wordWr   = ctl.capture && ctl.byteAddr[0];
  assign newWord  = {memRspData, lowByte};
  assign inRange1 = (wordIdx < WIDX_W'(CS1_IDX));
  assign inRange2 = (wordIdx >= WIDX_W'(SIG_IDX)) && (wordIdx < WIDX_W'(CS2_IDX));

  always_ff @(posedge clk) begin
    if (!rstN) lowByte <= '0;
    else if (ctl.capture && !ctl.byteAddr[0]) lowByte <= memRspData;
  end

  for (genvar w = 0; w < IMG_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) regFile[w] <= '0;
      else if (wordWr && (wordIdx == WIDX_W'(w))) regFile[w] <= newWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sum1 <= '0;
      sum2 <= '0;
    end else if (wordWr) begin
      if (inRange1) sum1 <= sum1 + newWord;
      if (inRange2) sum2 <= sum2 + newWord;
    end
  end

  assign sigOk = (regFile[SIG_IDX] == SIGNATURE);
  assign cs1Ok = (regFile[CS1_IDX] == ALL_ONES - sum1);
  assign cs2Ok = (regFile[CS2_IDX] == ALL_ONES - sum2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outEn     <= 1'b0;
      failFlags <= '0;
      lockReq   <= 1'b0;
    end else if (ctl.evaluate) begin
      outEn     <= sigOk && cs1Ok && cs2Ok;
      failFlags <= {!cs2Ok, !cs1Ok, !sigOk};
      lockReq   <= sigOk && cs1Ok && cs2Ok && regFile[LOCK_IDX][LOCK_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) earlyHost <= 1'b0;
    else if (hostStrobe && ctl.windowOpen) earlyHost <= 1'b1;
  end

  assign progEn = !(lockReq && !earlyHost);
  assign rdData = (rdAddr < WIDX_W'(IMG_WORDS)) ? regFile[rdAddr] : '0;
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
  import boot_cfg_pkg::*;
#(
  parameter int          START_DELAY  = 1650000,
  parameter int          EARLY_WINDOW = 1250000,
  parameter logic [15:0] SIGNATURE    = 16'h5A3C
) (
  input  logic        clk,
  input  logic        rstN,
  output logic        memReqValid,
  output logic [4:0]  memReqAddr,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic [7:0]  memRspData,
  input  logic        hostStrobe,
  input  logic [3:0]  rdAddr,
  output logic [15:0] rdData,
  output logic        loadDone,
  output logic        outEn,
  output logic [2:0]  failFlags,
  output logic        progEn
);
  loadCtl_t ctl;

  boot_cfg_ctrl #(
    .START_DELAY (START_DELAY),
    .EARLY_WINDOW(EARLY_WINDOW)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .memReqValid(memReqValid),
    .loadDone   (loadDone),
    .ctl        (ctl)
  );

  boot_cfg_dpath #(
    .SIGNATURE(SIGNATURE)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .memRspData(memRspData),
    .hostStrobe(hostStrobe),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .outEn     (outEn),
    .failFlags (failFlags),
    .progEn    (progEn)
  );

  assign memReqAddr = ctl.byteAddr;
endmodule

// File: rtl/boot_cfg_checker.sv
module boot_cfg_checker #(
  parameter int START_DELAY  = 1650000,
  parameter int EARLY_WINDOW = 1250000
) (
  input logic       clk,
  input logic       rstN,
  input logic       memReqValid,
  input logic [4:0] memReqAddr,
  input logic       memReqReady,
  input logic       loadDone,
  input logic       outEn,
  input logic [2:0] failFlags,
  input logic       progEn
);
  localparam int DLY_W = $clog2(START_DELAY + 1);

  logic [DLY_W-1:0] sinceRst;
  logic             doneSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= '0;
      doneSeen <= 1'b0;
    end else begin
      if (sinceRst != DLY_W'(START_DELAY)) sinceRst <= sinceRst + 1'b1;
      if (loadDone) doneSeen <= 1'b1;
    end
  end

  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> sinceRst == DLY_W'(START_DELAY)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr)); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqAddr < 5'd28); // R2
  AST_OUT_WAITS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !doneSeen && !loadDone |-> !outEn && failFlags == 3'b000); // R7
  AST_OUT_NEEDS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    outEn |-> failFlags == 3'b000); // R7
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |-> !loadDone); // R8
  AST_FINAL_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |=> $stable(outEn) && $stable(failFlags)); // R8
  AST_PROG_DURING_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !doneSeen && !loadDone |-> progEn); // R9
  AST_PROG_ON_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    failFlags != 3'b000 |-> progEn); // R11
endmodule

bind boot_cfg_loader boot_cfg_checker #(
  .START_DELAY (START_DELAY),
  .EARLY_WINDOW(EARLY_WINDOW)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReqValid(memReqValid),
  .memReqAddr (memReqAddr),
  .memReqReady(memReqReady),
  .loadDone   (loadDone),
  .outEn      (outEn),
  .failFlags  (failFlags),
  .progEn     (progEn)
);

// File: tb/boot_cfg_loader_bench.sv
module boot_cfg_loader_bench;
  localparam int          SD  = 40;
  localparam int          EW  = 25;
  localparam logic [15:0] SIG = 16'hC35A;
  localparam int          NV  = 8;

  typedef struct packed {
    logic [3:0] lat;
    logic       stall;
    logic [2:0] corrupt;  // 0 none, 1 sig, 2 cs1, 3 cs2, 4 all
    logic       dis;
    logic [1:0] host;     // 0 none, 1 early, 2 late
    logic       expOut;
    logic [2:0] expFlags;
    logic       expProg;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 3'd0, 1'b0, 2'd0, 1'b1, 3'b000, 1'b1},
    '{4'd3, 1'b1, 3'd0, 1'b1, 2'd0, 1'b1, 3'b000, 1'b0},
    '{4'd0, 1'b0, 3'd0, 1'b1, 2'd1, 1'b1, 3'b000, 1'b1},
    '{4'd2, 1'b0, 3'd0, 1'b1, 2'd2, 1'b1, 3'b000, 1'b0},
    '{4'd1, 1'b0, 3'd1, 1'b1, 2'd0, 1'b0, 3'b001, 1'b1},
    '{4'd4, 1'b1, 3'd2, 1'b0, 2'd0, 1'b0, 3'b010, 1'b1},
    '{4'd1, 1'b0, 3'd3, 1'b1, 2'd0, 1'b0, 3'b100, 1'b1},
    '{4'd2, 1'b1, 3'd4, 1'b1, 2'd0, 1'b0, 3'b111, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memReqValid;
  logic [4:0]  memReqAddr;
  logic        memReqReady;
  logic        memRspValid = 1'b0;
  logic [7:0]  memRspData = 8'h00;
  logic        hostStrobe = 1'b0;
  logic [3:0]  rdAddr = 4'd0;
  logic [15:0] rdData;
  logic        loadDone, outEn, progEn;
  logic [2:0]  failFlags;

  int errors = 0;
  int checks = 0;

  logic [7:0]  img [28];
  logic [15:0] expWords [14];
  logic        pending = 1'b0;
  logic [3:0]  latCnt = 4'd0;
  logic [4:0]  pAddr = 5'd0;
  logic        par = 1'b0;
  logic [3:0]  curLat = 4'd1;
  logic        curStall = 1'b0;

  always #10 clk = ~clk;

  boot_cfg_loader #(
    .START_DELAY(SD), .EARLY_WINDOW(EW), .SIGNATURE(SIG)
  ) u_boot_cfg_loader (
    .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqReady(memReqReady), .memRspValid(memRspValid), .memRspData(memRspData),
    .hostStrobe(hostStrobe), .rdAddr(rdAddr), .rdData(rdData), .loadDone(loadDone),
    .outEn(outEn), .failFlags(failFlags), .progEn(progEn)
  );

  // memory model: one outstanding byte read, programmable latency
  assign memReqReady = !pending && (!curStall || par);
  always @(posedge clk) begin
    par         <= ~par;
    memRspValid <= 1'b0;
    if (!rstN) begin
      pending <= 1'b0;
    end else if (pending) begin
      if (latCnt == 4'd0) begin
        memRspValid <= 1'b1;
        memRspData  <= img[pAddr];
        pending     <= 1'b0;
      end else begin
        latCnt <= latCnt - 1'b1;
      end
    end else if (memReqValid && memReqReady) begin
      pending <= 1'b1;
      pAddr   <= memReqAddr;
      latCnt  <= curLat;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic buildImage(input vec_t v, input int seed);
    logic [15:0] s1, s2;
    for (int k = 0; k < 14; k++)
      expWords[k] = 16'(k * 16'h3A57 + seed * 16'h1111 + 16'h8000);
    expWords[4][15] = v.dis;
    expWords[8] = SIG;
    if (v.corrupt == 3'd1 || v.corrupt == 3'd4) expWords[8] = expWords[8] ^ 16'h0040;
    s1 = '0;
    s2 = '0;
    for (int k = 0; k < 7; k++)  s1 = s1 + expWords[k];
    for (int k = 8; k < 13; k++) s2 = s2 + expWords[k];
    expWords[7]  = 16'hFFFF - s1;
    expWords[13] = 16'hFFFF - s2;
    if (v.corrupt == 3'd2 || v.corrupt == 3'd4) expWords[7] = expWords[7] ^ 16'h0100;
    if (v.corrupt == 3'd3 || v.corrupt == 3'd4) expWords[13] = expWords[13] + 16'd1;
    for (int k = 0; k < 14; k++) begin
      img[2*k]   = expWords[k][7:0];
      img[2*k+1] = expWords[k][15:8];
    end
  endtask

  task automatic runVector(input int idx);
    vec_t v;
    int   cyc, firstReq, extra, bad;
    bit   done;
    v = VECS[idx];
    buildImage(v, idx + 1);
    curLat   = v.lat;
    curStall = v.stall;
    rstN       = 1'b0;
    hostStrobe = 1'b0;
    repeat (3) @(negedge clk);
    if (idx == 0) begin
      check(outEn == 1'b0 && failFlags == 3'b000, "R7", "reset outEn/flags",
            {outEn, failFlags}, 0);
      check(progEn == 1'b1 && loadDone == 1'b0 && memReqValid == 1'b0, "R9",
            "reset progEn/done/req", {progEn, loadDone, memReqValid}, 3'b100);
    end
    rstN     = 1'b1;
    cyc      = 0;
    firstReq = -1;
    done     = 1'b0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (memReqValid && firstReq < 0) begin
        firstReq = cyc;
        check(progEn == 1'b1, "R9", "progEn during load", progEn, 1);
      end
      if (loadDone) done = 1'b1;
      hostStrobe = (v.host == 2'd1 && cyc == 5) || (v.host == 2'd2 && cyc == EW + 2);
    end
    hostStrobe = 1'b0;
    check(done, "R2", $sformatf("vec%0d load finished", idx), done, 1);
    check(firstReq == SD, "R1", $sformatf("vec%0d first request cycle", idx), firstReq, SD);
    check(failFlags[0] == v.expFlags[0], "R4", $sformatf("vec%0d signature flag", idx),
          failFlags[0], v.expFlags[0]);
    check(failFlags[1] == v.expFlags[1], "R5", $sformatf("vec%0d checksum1 flag", idx),
          failFlags[1], v.expFlags[1]);
    check(failFlags[2] == v.expFlags[2], "R6", $sformatf("vec%0d checksum2 flag", idx),
          failFlags[2], v.expFlags[2]);
    check(outEn == v.expOut, "R7", $sformatf("vec%0d outEn", idx), outEn, v.expOut);
    check(progEn == v.expProg, v.host != 2'd0 ? "R10" : (v.expFlags != 0 ? "R11" : "R9"),
          $sformatf("vec%0d progEn", idx), progEn, v.expProg);
    bad = 0;
    for (int k = 0; k < 16; k++) begin
      rdAddr = 4'(k);
      #1;
      if (rdData !== (k < 14 ? expWords[k] : 16'h0000)) begin
        bad++;
        check(1'b0, "R3", $sformatf("vec%0d word %0d", idx, k), rdData,
              k < 14 ? expWords[k] : 0);
      end
    end
    if (bad == 0) check(1'b1, "R3", "readback", 0, 0);
    extra = 0;
    repeat (12) begin
      @(negedge clk);
      if (loadDone) extra++;
    end
    check(extra == 0 && outEn == v.expOut, "R8", $sformatf("vec%0d single done, stable", idx),
          extra, 0);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) runVector(i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule